// File: doc/BRIEF.md
# Channel Error Logout Writer

This block records the state of a failing channel in memory. A channel-control or interface-control check, or a processor error that occurs while a channel operation is in progress, starts a capture. In that same cycle the block latches the channel status word and a snapshot of internal channel state. It then writes the status word to a fixed location. When the extended-log mask is set, it also reads a pointer from a fixed word address and writes the snapshot as a block of words starting at that pointer. After the last store it raises an I/O interrupt request and holds it until software acknowledges it.

Memory is reached through a single-beat port. The block holds a request, with its address and data, until the port grants it. At most one transfer completes per cycle. An error that arrives while a capture is already in progress does not start a second capture. It sets a sticky overrun flag instead.

Top module: `chan_logout_writer`

## Requirements
- R1: A pulse on either `chan_chk_i` or `cpu_chk_i` while the block is idle starts a capture. The first transfer of every capture is a write of the latched status word to word address `STAT_SLOT` (default 64).
- R2: When the mask was set in the error cycle, the next transfer after the status write is a read of word address `PTR_SLOT` (default 112). The low `ADDR_W` bits of the returned word become the base address of the log block.
- R3: With the mask set, after the pointer read the block writes exactly `LOG_WORDS` (default 28) words to base, base+1, and so on up to base+LOG_WORDS-1, in that order. Word k is bits [k*DATA_W +: DATA_W] of the snapshot.
- R4: `ext_log_en_i` is sampled in the error cycle only. When it was clear, the capture makes no read and no log writes: only the status write, followed by the interrupt.
- R5: The status word and the snapshot are latched in the error cycle. Later changes on `stat_word_i`, `snap_i` or `ext_log_en_i` do not alter any value the capture writes.
- R6: A pending request keeps its direction, address and data unchanged until `mem_gnt_i` is high. A transfer completes in each cycle where a request and the grant are both high. Read and write are never requested together.
- R7: `irq_o` rises in the cycle after the last transfer is granted. It stays high, with no memory request, until `irq_ack_i` is sampled high, and it is low in the following cycle.
- R8: An error pulse that arrives while a capture is in progress, up to and including the interrupt wait, sets `overrun_o`. It causes no extra transfers. `overrun_o` stays high until reset.
- R9: After a synchronous active-low reset, no request is made and `irq_o` and `overrun_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| chan_chk_i | input | 1 | Channel-control or interface-control check pulse |
| cpu_chk_i | input | 1 | Processor error during a channel operation, pulse |
| stat_word_i | input | DATA_W | Current channel status word |
| snap_i | input | LOG_WORDS*DATA_W | Internal channel state snapshot, word k at bits k*DATA_W |
| ext_log_en_i | input | 1 | Extended-log mask |
| mem_wr_o | output | 1 | Write request |
| mem_rd_o | output | 1 | Read request |
| mem_addr_o | output | ADDR_W | Word address of the request |
| mem_wdata_o | output | DATA_W | Write data |
| mem_rdata_i | input | ADDR_W | Pointer bits of the read word, valid in the granted cycle |
| mem_gnt_i | input | 1 | Grant; the transfer completes in this cycle |
| irq_o | output | 1 | I/O interrupt request |
| irq_ack_i | input | 1 | Interrupt acknowledge |
| overrun_o | output | 1 | Sticky flag: error arrived while busy |

## Verification
The status write is requested in the cycle after the error is sampled. Each later transfer is requested in the cycle after the previous one is granted. The interrupt rises one cycle after the final grant and falls one cycle after the acknowledge. The overrun flag shows one cycle after the extra error. The bench drives inputs and changes the grant just after rising edges, and it reads every output at the falling edge. A transfer is compared against the head of the expected queue exactly when request and grant are both high. The bench also checks, cycle by cycle, that a request left waiting is unchanged at the next falling edge.

// File: rtl/clw_pkg.sv
// Shared types for the channel error logout writer.
// Assumes nothing beyond a single clock domain.
package clw_pkg;

    typedef enum logic [2:0] {
        S_IDLE = 3'd0,
        S_STAT = 3'd1,
        S_PTR  = 3'd2,
        S_LOG  = 3'd3,
        S_IRQ  = 3'd4
    } clw_state_e;

endpackage

// File: rtl/clw_capture.sv
// Snapshot store: latches the status word and every snapshot word in the
// error cycle and returns the word selected by the log index.
// Assumes cap_en_i is high for exactly the cycle that starts a capture.
module clw_capture #(
    parameter int DATA_W    = 32,
    parameter int LOG_WORDS = 28,
    parameter int IDX_W     = 5
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cap_en_i,
    input  logic [DATA_W-1:0]           stat_i,
    input  logic [LOG_WORDS*DATA_W-1:0] snap_i,
    input  logic [IDX_W-1:0]            rd_idx_i,
    output logic [DATA_W-1:0]           stat_q_o,
    output logic [DATA_W-1:0]           word_o
);

    logic [DATA_W-1:0] words_q [LOG_WORDS];

    // Hold the status word taken in the error cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q_o <= '0;
        end else if (cap_en_i) begin
            stat_q_o <= stat_i;
        end
    end

    // One register per snapshot word, loaded together on capture.
    for (genvar w = 0; w < LOG_WORDS; w++) begin : g_word
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                words_q[w] <= '0;
            end else if (cap_en_i) begin
                words_q[w] <= snap_i[w*DATA_W +: DATA_W];
            end
        end
    end

    // Select the word for the current log beat, guarded against idle indexes.
    always_comb begin
        word_o = '0;
        for (int k = 0; k < LOG_WORDS; k++) begin
            if (32'(rd_idx_i) == k) begin
                word_o = words_q[k];
            end
        end
    end

endmodule

// File: rtl/clw_seq.sv
// Capture sequencer: steps through status store, pointer fetch, log burst
// and interrupt wait; tracks the log index, base address and overrun flag.
// Assumes gnt_i is meaningful only while this sequencer requests a transfer.
module clw_seq
    import clw_pkg::*;
#(
    parameter int ADDR_W    = 24,
    parameter int LOG_WORDS = 28,
    parameter int IDX_W     = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              err_i,
    input  logic              mask_i,
    input  logic              gnt_i,
    input  logic              ack_i,
    input  logic [ADDR_W-1:0] rdata_i,
    output clw_state_e        state_o,
    output logic [IDX_W-1:0]  idx_o,
    output logic [ADDR_W-1:0] base_o,
    output logic              cap_en_o,
    output logic              irq_o,
    output logic              overrun_o
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(LOG_WORDS - 1);

    clw_state_e state_q, state_d;
    logic       mask_q;
    logic       start;

    assign start    = err_i && (state_q == S_IDLE);
    assign cap_en_o = start;
    assign state_o  = state_q;
    assign irq_o    = (state_q == S_IRQ);

    // Next-state selection for the capture sequence.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (err_i) state_d = S_STAT;
            S_STAT: if (gnt_i) state_d = mask_q ? S_PTR : S_IRQ;
            S_PTR:  if (gnt_i) state_d = S_LOG;
            S_LOG:  if (gnt_i && idx_o == LAST_IDX) state_d = S_IRQ;
            S_IRQ:  if (ack_i) state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Mask is taken once, in the error cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)     mask_q <= 1'b0;
        else if (start) mask_q <= mask_i;
    end

    // Base address from the pointer read and log beat counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_o <= '0;
            idx_o  <= '0;
        end else if (state_q == S_PTR && gnt_i) begin
            base_o <= rdata_i;
            idx_o  <= '0;
        end else if (state_q == S_LOG && gnt_i && idx_o != LAST_IDX) begin
            idx_o  <= idx_o + 1'b1;
        end
    end

    // Sticky overrun when an error lands outside idle.
    always_ff @(posedge clk) begin
        if (!rst_n)                            overrun_o <= 1'b0;
        else if (err_i && state_q != S_IDLE)   overrun_o <= 1'b1;
    end

    // R7
    irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !ack_i) |=> irq_o);

    // R7
    irq_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && ack_i) |=> !irq_o);

    // R8
    overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        overrun_o |=> overrun_o);

    // R3
    log_idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_LOG) |-> (idx_o <= LAST_IDX));

    // R4
    skip_log_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_STAT && gnt_i && !mask_q) |=> (state_q == S_IRQ));

endmodule

// File: rtl/clw_port.sv
// Memory port driver: turns the sequencer state into single-beat read or
// write requests with their address and data.
// Assumes the requester holds its state until the grant arrives.
module clw_port
    import clw_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 24,
    parameter int IDX_W     = 5,
    parameter int STAT_SLOT = 64,
    parameter int PTR_SLOT  = 112
) (
    input  logic              clk,
    input  logic              rst_n,
    input  clw_state_e        state_i,
    input  logic [IDX_W-1:0]  idx_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic [DATA_W-1:0] stat_i,
    input  logic [DATA_W-1:0] word_i,
    input  logic              gnt_i,
    output logic              wr_o,
    output logic              rd_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W-1:0] wdata_o
);

    // Build the request for the current step.
    always_comb begin
        wr_o    = 1'b0;
        rd_o    = 1'b0;
        addr_o  = '0;
        wdata_o = '0;
        unique case (state_i)
            S_STAT: begin
                wr_o    = 1'b1;
                addr_o  = ADDR_W'(STAT_SLOT);
                wdata_o = stat_i;
            end
            S_PTR: begin
                rd_o    = 1'b1;
                addr_o  = ADDR_W'(PTR_SLOT);
            end
            S_LOG: begin
                wr_o    = 1'b1;
                addr_o  = base_i + ADDR_W'(idx_i);
                wdata_o = word_i;
            end
            default: ;
        endcase
    end

    // R6
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((wr_o || rd_o) && !gnt_i) |=>
        ($stable(wr_o) && $stable(rd_o) && $stable(addr_o) && $stable(wdata_o)));

    // R6
    single_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_o, rd_o}));

endmodule

// File: rtl/chan_logout_writer.sv
// Channel error logout writer top: on a channel or processor check it
// latches the status word and snapshot, stores the status word, optionally
// writes the snapshot block at a pointer fetched from a fixed word, then
// raises an interrupt request until acknowledged.
// Assumes error inputs are single-cycle pulses in the clk domain.
module chan_logout_writer #(
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 24,
    parameter int LOG_WORDS = 28,
    parameter int STAT_SLOT = 64,
    parameter int PTR_SLOT  = 112
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        chan_chk_i,
    input  logic                        cpu_chk_i,
    input  logic [DATA_W-1:0]           stat_word_i,
    input  logic [LOG_WORDS*DATA_W-1:0] snap_i,
    input  logic                        ext_log_en_i,
    output logic                        mem_wr_o,
    output logic                        mem_rd_o,
    output logic [ADDR_W-1:0]           mem_addr_o,
    output logic [DATA_W-1:0]           mem_wdata_o,
    input  logic [ADDR_W-1:0]           mem_rdata_i,
    input  logic                        mem_gnt_i,
    output logic                        irq_o,
    input  logic                        irq_ack_i,
    output logic                        overrun_o
);
    import clw_pkg::*;

    localparam int IDX_W = (LOG_WORDS > 1) ? $clog2(LOG_WORDS) : 1;

    logic              err;
    logic              cap_en;
    clw_state_e        state;
    logic [IDX_W-1:0]  idx;
    logic [ADDR_W-1:0] base;
    logic [DATA_W-1:0] stat_q;
    logic [DATA_W-1:0] word;

    // Either check source starts a capture.
    assign err = chan_chk_i | cpu_chk_i;

    clw_seq #(
        .ADDR_W(ADDR_W), .LOG_WORDS(LOG_WORDS), .IDX_W(IDX_W)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .err_i(err), .mask_i(ext_log_en_i),
        .gnt_i(mem_gnt_i), .ack_i(irq_ack_i), .rdata_i(mem_rdata_i),
        .state_o(state), .idx_o(idx), .base_o(base), .cap_en_o(cap_en),
        .irq_o(irq_o), .overrun_o(overrun_o)
    );

    clw_capture #(
        .DATA_W(DATA_W), .LOG_WORDS(LOG_WORDS), .IDX_W(IDX_W)
    ) u_cap (
        .clk(clk), .rst_n(rst_n), .cap_en_i(cap_en), .stat_i(stat_word_i),
        .snap_i(snap_i), .rd_idx_i(idx), .stat_q_o(stat_q), .word_o(word)
    );

    clw_port #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W), .IDX_W(IDX_W),
        .STAT_SLOT(STAT_SLOT), .PTR_SLOT(PTR_SLOT)
    ) u_port (
        .clk(clk), .rst_n(rst_n), .state_i(state), .idx_i(idx),
        .base_i(base), .stat_i(stat_q), .word_i(word), .gnt_i(mem_gnt_i),
        .wr_o(mem_wr_o), .rd_o(mem_rd_o), .addr_o(mem_addr_o),
        .wdata_o(mem_wdata_o)
    );

    // R7
    irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (!mem_wr_o && !mem_rd_o));

endmodule

// File: tb/chan_logout_writer_tb.sv
module chan_logout_writer_tb_top;

    localparam int DW = 32;
    localparam int AW = 24;
    localparam int NW = 28;
    localparam int STAT_A = 64;
    localparam int PTR_A = 112;

    typedef struct {
        bit          is_rd;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
        string       tag;
    } item_t;

    logic clk = 0, rst_n = 0;
    logic chan_chk_i = 0, cpu_chk_i = 0, ext_log_en_i = 0;
    logic [DW-1:0] stat_word_i = '0;
    logic [NW*DW-1:0] snap_i = '0;
    logic mem_wr_o, mem_rd_o, irq_o, overrun_o;
    logic [AW-1:0] mem_addr_o;
    logic [DW-1:0] mem_wdata_o;
    logic [AW-1:0] mem_rdata_i = '0;
    logic mem_gnt_i = 1'b1;
    logic irq_ack_i = 0;

    int n_run = 0, n_fail = 0, cyc = 0;
    bit throttle = 0;
    item_t sb_q[$];

    logic          p_req = 0, p_gnt = 0, p_wr = 0;
    logic [AW-1:0] p_addr = '0;
    logic [DW-1:0] p_data = '0;

    chan_logout_writer #(.DATA_W(DW), .ADDR_W(AW), .LOG_WORDS(NW),
        .STAT_SLOT(STAT_A), .PTR_SLOT(PTR_A)) dut_i (
        .clk(clk), .rst_n(rst_n), .chan_chk_i(chan_chk_i), .cpu_chk_i(cpu_chk_i),
        .stat_word_i(stat_word_i), .snap_i(snap_i), .ext_log_en_i(ext_log_en_i),
        .mem_wr_o(mem_wr_o), .mem_rd_o(mem_rd_o), .mem_addr_o(mem_addr_o),
        .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i), .mem_gnt_i(mem_gnt_i),
        .irq_o(irq_o), .irq_ack_i(irq_ack_i), .overrun_o(overrun_o)
    );

    always #10 clk = ~clk;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] pat(input logic [DW-1:0] seed, input int k);
        return (seed * 32'h0100_0193) ^ (32'(k) * 32'h9E37_79B9);
    endfunction

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d expected <20000", cyc);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    // Grant pattern changes just after each rising edge.
    always @(posedge clk) mem_gnt_i <= throttle ? ((cyc % 3) != 1) : 1'b1;

    // Monitor: pop and compare each granted transfer; check held requests.
    always @(negedge clk) begin
        if (rst_n) begin
            if (p_req && !p_gnt)
                check((mem_wr_o | mem_rd_o) && mem_wr_o == p_wr && mem_addr_o == p_addr
                      && mem_wdata_o == p_data, "R6", "held request changed",
                      {mem_wr_o, mem_addr_o, mem_wdata_o}, {p_wr, p_addr, p_data});
            check(!(mem_wr_o && mem_rd_o), "R6", "read and write together",
                  {mem_wr_o, mem_rd_o}, 0);
            if ((mem_wr_o || mem_rd_o) && mem_gnt_i) begin
                if (sb_q.size() == 0) begin
                    check(0, "R4", "unexpected transfer addr", mem_addr_o, 0);
                end else begin
                    item_t e;
                    e = sb_q.pop_front();
                    check(mem_rd_o == e.is_rd, e.tag, "direction", mem_rd_o, e.is_rd);
                    check(mem_addr_o == e.addr, e.tag, "address", mem_addr_o, e.addr);
                    if (!e.is_rd)
                        check(mem_wdata_o == e.data, e.tag, "data", mem_wdata_o, e.data);
                end
            end
        end
        p_req  = mem_wr_o | mem_rd_o;
        p_gnt  = mem_gnt_i;
        p_wr   = mem_wr_o;
        p_addr = mem_addr_o;
        p_data = mem_wdata_o;
    end

    // Driver: pulse an error, push the expected transfers, then scramble inputs.
    task automatic fire(input bit use_cpu, input bit mask,
                        input logic [DW-1:0] seed, input logic [AW-1:0] ptr);
        item_t it;
        @(negedge clk);
        stat_word_i  = seed ^ 32'hA5A5_0F0F;
        for (int k = 0; k < NW; k++) snap_i[k*DW +: DW] = pat(seed, k);
        ext_log_en_i = mask;
        mem_rdata_i  = ptr;
        if (use_cpu) cpu_chk_i = 1; else chan_chk_i = 1;
        it = '{0, AW'(STAT_A), stat_word_i, "R1"};
        sb_q.push_back(it);
        if (mask) begin
            it = '{1, AW'(PTR_A), '0, "R2"};
            sb_q.push_back(it);
            for (int k = 0; k < NW; k++) begin
                it = '{0, ptr + AW'(k), pat(seed, k), (k == 0) ? "R5" : "R3"};
                sb_q.push_back(it);
            end
        end
        @(negedge clk);
        cpu_chk_i = 0; chan_chk_i = 0;
        stat_word_i = ~stat_word_i;            // R5: later changes ignored
        snap_i = ~snap_i;
        ext_log_en_i = ~mask;                  // R4: mask sampled once
    endtask

    task automatic finish_irq();
        int t = 0;
        while (!irq_o && t < 3000) begin @(negedge clk); t++; end
        check(irq_o, "R7", "irq raised", irq_o, 1);
        check(sb_q.size() == 0, "R7", "transfers left at irq", sb_q.size(), 0);
        repeat (3) @(negedge clk);
        check(irq_o && !mem_wr_o && !mem_rd_o, "R7", "irq held quiet",
              {irq_o, mem_wr_o, mem_rd_o}, 3'b100);
        irq_ack_i = 1;
        @(negedge clk);
        irq_ack_i = 0;
        check(!irq_o, "R7", "irq after ack", irq_o, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        // R9: reset state
        check(!mem_wr_o && !mem_rd_o, "R9", "request in reset", {mem_wr_o, mem_rd_o}, 0);
        check(!irq_o, "R9", "irq in reset", irq_o, 0);
        check(!overrun_o, "R9", "overrun in reset", overrun_o, 0);
        rst_n = 1;
        repeat (2) @(negedge clk);

        // Channel check, mask set, grant always (R1 R2 R3 R5)
        fire(0, 1, 32'h1234_5678, 24'h000400);
        finish_irq();
        check(!overrun_o, "R8", "no overrun for single error", overrun_o, 0);

        // Processor check, mask clear: status only (R1 R4)
        fire(1, 0, 32'h0BAD_F00D, 24'h000800);
        finish_irq();
        repeat (3) @(negedge clk);
        check(sb_q.size() == 0 && !mem_wr_o && !mem_rd_o, "R4", "idle after short capture",
              sb_q.size(), 0);

        // Throttled grant, pointer near top of space, second error while busy (R6 R8)
        throttle = 1;
        fire(0, 1, 32'hCAFE_0001, 24'hFFFFE0);
        repeat (5) @(negedge clk);
        chan_chk_i = 1;
        @(negedge clk);
        chan_chk_i = 0;
        check(overrun_o, "R8", "overrun set", overrun_o, 1);
        finish_irq();
        repeat (2) @(negedge clk);
        check(overrun_o, "R8", "overrun sticky", overrun_o, 1);
        check(sb_q.size() == 0 && !mem_wr_o && !mem_rd_o, "R8", "no extra capture",
              sb_q.size(), 0);

        // Reset clears the flag (R9)
        rst_n = 0;
        @(negedge clk);
        @(negedge clk);
        check(!overrun_o && !irq_o, "R9", "flags after reset", {overrun_o, irq_o}, 0);
        rst_n = 1;
        throttle = 0;

        // Mask set with grant throttled from the start, processor source (R2 R3)
        throttle = 1;
        fire(1, 1, 32'h7777_2222, 24'h001000);
        finish_irq();

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule